// File: doc/BRIEF.md
# SPI Bus Sniffer

This block listens to a four-wire SPI bus without ever driving it. It runs on a fast system clock and first passes the serial clock, both data lines and the chip select through two-stage synchronisers. It then finds serial-clock transitions by comparing each synchronised sample with the one before it. On every transition that matches the configured capture edge, it takes one bit from the controller-to-peripheral line and one bit from the peripheral-to-controller line, and places each bit in its own accumulator.

Once the configured number of bits has been gathered, the block presents both words together with a one-cycle strobe and advances a word counter. It also reports whether chip select was at its inactive level when the first bit of that word was taken. Such words are still delivered, but carry this flag.

Clock polarity, clock phase, bit order, word length and chip-select polarity are static configuration inputs. They are changed only while the block is held in reset. A word length of 0, or any value above 64, is treated as 64.

A small controller tracks word progress in two states. `ST_IDLE` means no bit of the current word has been taken yet. `ST_SHIFT` means a word is partly collected. The transitions are:
- `IDLE->SHIFT` on a capture edge when the word needs more than one bit.
- `SHIFT->IDLE` on the capture edge that takes the final bit.
- `IDLE->IDLE` on a capture edge when the word length is 1.
- No transition on any other cycle.

Top module: `spi_sniffer`

## Requirements
- R1: After a synchronous reset, `word_valid` is 0, `word_count` is 0, and both word outputs and the flag are 0.
- R2: The capture edge depends on the mode given by (`cfg_cpol`, `cfg_cpha`): (0,0)=mode 0, (0,1)=mode 1, (1,0)=mode 2, (1,1)=mode 3. Modes 0 and 3 capture on a rising serial-clock edge. Modes 1 and 2 capture on a falling edge.
- R3: System-clock cycles in which the synchronised serial clock does not change take no bit. Toggling the data or select lines while the serial clock is held still produces no word and leaves the count unchanged.
- R4: With `cfg_lsb_first`=0, the bit taken k-th (counting from 0) in a word of N bits is placed at position N-1-k.
- R5: With `cfg_lsb_first`=1, the bit taken k-th is placed at position k.
- R6: Both data lines are captured on the same edge. Their words appear together on `word_mosi` and `word_miso` in the cycle `word_valid` is 1.
- R7: The word length is 1 to 64 bits, and bits at or above the word length are 0 on the outputs.
- R8: `word_valid` is a single-cycle pulse that occurs once per completed word. It is registered one system clock after the cycle in which the final capture edge is seen at the synchroniser output. `word_count` increases by exactly one with each pulse.
- R9: `word_cs_warn` is 1 with a word exactly when chip select was at its inactive level as the word's first bit was taken. The flag does not carry over into the next word.
- R10: With `cfg_cs_active_high`=0, chip select is active when low. With `cfg_cs_active_high`=1, it is active when high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpol | input | 1 | Serial-clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1: first bit is the LSB |
| cfg_cs_active_high | input | 1 | 1: chip select is active high |
| cfg_word_len | input | 7 | Bits per word, 1 to 64 |
| spi_sck | input | 1 | Bus serial clock |
| spi_mosi | input | 1 | Controller-to-peripheral data |
| spi_miso | input | 1 | Peripheral-to-controller data |
| spi_cs | input | 1 | Bus chip select |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_mosi | output | 64 | Captured controller word, zero-extended |
| word_miso | output | 64 | Captured peripheral word, zero-extended |
| word_cs_warn | output | 1 | Chip select was inactive at the first bit |
| word_count | output | 16 | Completed-word counter, wraps |

## Verification
The assertions check several properties on every cycle:
- The strobe never lasts two cycles.
- The counter steps by exactly one with each strobe.
- The controller is in `ST_IDLE` only while no bits are pending.
- The bit counter stays put on cycles without a capture edge.
- Bits above the word length are clear on the outputs.

Other behaviours need whole bus transactions, so only the bench scenarios can show them:
- The correct capture edge is chosen for each of the four modes.
- Bits land at the right positions in either order.
- The chip-select flag is judged against the configured polarity.
- A held serial clock takes no data.

// File: rtl/sniff_pkg.sv
package sniff_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } sniff_state_t;

    // Modes 0 and 3 capture on a rising edge, modes 1 and 2 on a falling edge.
    function automatic logic capture_on_rise(input logic cpol, input logic cpha);
        return ~(cpol ^ cpha);
    endfunction

endpackage

// File: rtl/sniff_sync.sv
module sniff_sync #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] rst_val,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic meta_q;
        logic stable_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q   <= rst_val[g];
                stable_q <= rst_val[g];
            end else begin
                meta_q   <= din[g];
                stable_q <= meta_q;
            end
        end
        assign dout[g] = stable_q;
    end
endmodule

// File: rtl/sniff_edge.sv
module sniff_edge
    import sniff_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpol,
    input  logic cpha,
    input  logic sck_s,
    output logic sample
);
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= cpol;
        else     prev_q <= sck_s;
    end

    assign rise   = sck_s & ~prev_q;
    assign fall   = ~sck_s & prev_q;
    assign sample = capture_on_rise(cpol, cpha) ? rise : fall;
endmodule

// File: rtl/sniff_collect.sv
module sniff_collect #(
    parameter int MAX_W  = 64,
    parameter int CNT_W  = 16,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_i,
    input  logic             first_i,
    input  logic             lsb_first_i,
    input  logic [LEN_W-1:0] word_len_i,
    input  logic             mosi_i,
    input  logic             miso_i,
    input  logic             cs_idle_i,
    output logic [LEN_W-1:0] bit_cnt_o,
    output logic             last_o,
    output logic             valid_o,
    output logic [MAX_W-1:0] mosi_o,
    output logic [MAX_W-1:0] miso_o,
    output logic             warn_o,
    output logic [CNT_W-1:0] count_o
);
    logic [LEN_W-1:0] cnt_q;
    logic [MAX_W-1:0] acc_mosi_q, acc_miso_q;
    logic             warn_q;
    logic [LEN_W-1:0] pos;
    logic [MAX_W-1:0] bit_sel;
    logic [MAX_W-1:0] nxt_mosi, nxt_miso;
    logic             nxt_warn;

    assign last_o    = (cnt_q + LEN_W'(1)) == word_len_i;
    assign bit_cnt_o = cnt_q;

    always_comb begin
        pos      = lsb_first_i ? cnt_q : (word_len_i - LEN_W'(1) - cnt_q);
        bit_sel  = MAX_W'(1) << pos;
        nxt_mosi = mosi_i ? (acc_mosi_q | bit_sel) : acc_mosi_q;
        nxt_miso = miso_i ? (acc_miso_q | bit_sel) : acc_miso_q;
        nxt_warn = first_i ? cs_idle_i : warn_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            acc_mosi_q <= '0;
            acc_miso_q <= '0;
            warn_q     <= 1'b0;
            valid_o    <= 1'b0;
            mosi_o     <= '0;
            miso_o     <= '0;
            warn_o     <= 1'b0;
            count_o    <= '0;
        end else begin
            valid_o <= sample_i && last_o;
            if (sample_i) begin
                if (last_o) begin
                    mosi_o     <= nxt_mosi;
                    miso_o     <= nxt_miso;
                    warn_o     <= nxt_warn;
                    count_o    <= count_o + CNT_W'(1);
                    cnt_q      <= '0;
                    acc_mosi_q <= '0;
                    acc_miso_q <= '0;
                    warn_q     <= 1'b0;
                end else begin
                    cnt_q      <= cnt_q + LEN_W'(1);
                    acc_mosi_q <= nxt_mosi;
                    acc_miso_q <= nxt_miso;
                    warn_q     <= nxt_warn;
                end
            end
        end
    end

    // R3: no capture edge, no change to the bit count
    assert_hold_without_edge_R3: assert property (@(posedge clk) disable iff (rst)
        !sample_i |=> $stable(cnt_q));
endmodule

// File: rtl/spi_sniffer.sv
module spi_sniffer
    import sniff_pkg::*;
#(
    parameter int MAX_W  = 64,
    parameter int CNT_W  = 16,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic             cfg_cs_active_high,
    input  logic [LEN_W-1:0] cfg_word_len,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    input  logic             spi_miso,
    input  logic             spi_cs,
    output logic             word_valid,
    output logic [MAX_W-1:0] word_mosi,
    output logic [MAX_W-1:0] word_miso,
    output logic             word_cs_warn,
    output logic [CNT_W-1:0] word_count
);
    logic [3:0]       sync_out;
    logic             sck_s, mosi_s, miso_s, cs_s;
    logic             sample;
    logic             cs_idle;
    logic [LEN_W-1:0] len_eff;
    logic [LEN_W-1:0] bit_cnt;
    logic             last_bit;
    logic             first_bit;
    sniff_state_t     state_q, state_d;

    sniff_sync #(.LINES(4)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .rst_val({cfg_cpol, 3'b000}),
        .din    ({spi_sck, spi_mosi, spi_miso, spi_cs}),
        .dout   (sync_out)
    );
    assign {sck_s, mosi_s, miso_s, cs_s} = sync_out;

    sniff_edge i_edge (
        .clk   (clk),
        .rst   (rst),
        .cpol  (cfg_cpol),
        .cpha  (cfg_cpha),
        .sck_s (sck_s),
        .sample(sample)
    );

    assign cs_idle = cfg_cs_active_high ? ~cs_s : cs_s;
    assign len_eff = (cfg_word_len == '0 || cfg_word_len > LEN_W'(MAX_W))
                     ? LEN_W'(MAX_W) : cfg_word_len;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state and controller outputs
    always_comb begin
        state_d   = state_q;
        first_bit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                first_bit = 1'b1;
                if (sample && !last_bit) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sample && last_bit) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    sniff_collect #(.MAX_W(MAX_W), .CNT_W(CNT_W)) i_collect (
        .clk        (clk),
        .rst        (rst),
        .sample_i   (sample),
        .first_i    (first_bit),
        .lsb_first_i(cfg_lsb_first),
        .word_len_i (len_eff),
        .mosi_i     (mosi_s),
        .miso_i     (miso_s),
        .cs_idle_i  (cs_idle),
        .bit_cnt_o  (bit_cnt),
        .last_o     (last_bit),
        .valid_o    (word_valid),
        .mosi_o     (word_mosi),
        .miso_o     (word_miso),
        .warn_o     (word_cs_warn),
        .count_o    (word_count)
    );

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> word_count == $past(word_count) + CNT_W'(1));

    assert_idle_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (bit_cnt == '0));

    assert_high_bits_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (word_valid && len_eff < LEN_W'(MAX_W)) |->
            ((word_mosi >> len_eff) == '0 && (word_miso >> len_eff) == '0));
endmodule

// File: tb/test_spi_sniffer.sv
module test_spi_sniffer;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_cs_active_high = 1'b0;
    logic [6:0]  cfg_word_len = 7'd8;
    logic        spi_sck = 1'b0, spi_mosi = 1'b0, spi_miso = 1'b0, spi_cs = 1'b1;
    logic        word_valid;
    logic [63:0] word_mosi, word_miso;
    logic        word_cs_warn;
    logic [15:0] word_count;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    spi_sniffer i_spi_sniffer (
        .clk(clk), .rst(rst),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_cs_active_high(cfg_cs_active_high), .cfg_word_len(cfg_word_len),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs),
        .word_valid(word_valid), .word_mosi(word_mosi), .word_miso(word_miso),
        .word_cs_warn(word_cs_warn), .word_count(word_count)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference: pin history queue, word assembly by index
    logic [3:0]  hq0, hq1, hq2;
    int          mk;
    logic [63:0] mm, mi;
    logic        mw;
    logic        m_valid, m_warn;
    logic [63:0] m_mosi, m_miso;
    logic [15:0] m_count;

    always @(posedge clk) begin
        m_valid = 1'b0;
        if (rst) begin
            hq0 = {cfg_cpol, 3'b000}; hq1 = hq0; hq2 = hq0;
            mk = 0; mm = '0; mi = '0; mw = 1'b0;
            m_mosi = '0; m_miso = '0; m_warn = 1'b0; m_count = '0;
        end else begin
            if (hq1[3] != hq2[3] && hq1[3] == ~(cfg_cpol ^ cfg_cpha)) begin
                int len;
                int pos;
                len = int'(cfg_word_len);
                if (mk == 0) mw = cfg_cs_active_high ? ~hq1[0] : hq1[0];
                pos = cfg_lsb_first ? mk : len - 1 - mk;
                mm[pos] = hq1[2];
                mi[pos] = hq1[1];
                mk++;
                if (mk == len) begin
                    m_valid = 1'b1; m_mosi = mm; m_miso = mi; m_warn = mw;
                    m_count = m_count + 16'd1;
                    mm = '0; mi = '0; mk = 0; mw = 1'b0;
                end
            end
            hq2 = hq1; hq1 = hq0;
            hq0 = {spi_sck, spi_mosi, spi_miso, spi_cs};
        end
    end

    logic [63:0] got_mosi, got_miso;
    logic        got_warn;
    int          got_n = 0;

    always @(negedge clk) begin
        if (!rst) begin
            check("R8 valid strobe", 64'(word_valid), 64'(m_valid));
            check("R8 word count", 64'(word_count), 64'(m_count));
            if (m_valid) begin
                check("R6 mosi word", word_mosi, m_mosi);
                check("R6 miso word", word_miso, m_miso);
                check("R9 warn flag", 64'(word_cs_warn), 64'(m_warn));
            end
        end
        if (word_valid) begin
            got_mosi = word_mosi; got_miso = word_miso; got_warn = word_cs_warn; got_n++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic configure(input logic cpol, input logic cpha, input logic lsb,
                             input logic csah, input logic [6:0] len);
        @(negedge clk);
        rst = 1'b1;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
        cfg_cs_active_high = csah; cfg_word_len = len;
        spi_sck = cpol; spi_cs = ~csah;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] vm, input logic [63:0] vi, input int n, input logic cs_lvl);
        spi_cs = cs_lvl;
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = cfg_lsb_first ? k : n - 1 - k;
            if (cfg_cpha) begin
                spi_sck = ~cfg_cpol;
                spi_mosi = vm[idx]; spi_miso = vi[idx];
                repeat (H) @(negedge clk);
                spi_sck = cfg_cpol;
                repeat (H) @(negedge clk);
            end else begin
                spi_mosi = vm[idx]; spi_miso = vi[idx];
                repeat (H) @(negedge clk);
                spi_sck = ~cfg_cpol;
                repeat (H) @(negedge clk);
                spi_sck = cfg_cpol;
            end
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int n0;
        // R1: reset state
        configure(1'b0, 1'b0, 1'b0, 1'b0, 7'd8);
        check("R1 valid after reset", 64'(word_valid), 64'd0);
        check("R1 count after reset", 64'(word_count), 64'd0);
        check("R1 mosi after reset", word_mosi, 64'd0);
        check("R1 miso/warn after reset", {word_miso[62:0], word_cs_warn}, 64'd0);

        // R2 R4 R6 mode 0, MSB first
        send(64'hA5, 64'h3C, 8, 1'b0);
        check("R4 mode0 msb mosi", got_mosi, 64'hA5);
        check("R6 mode0 miso", got_miso, 64'h3C);
        check("R9 active cs no warn", 64'(got_warn), 64'd0);

        configure(1'b0, 1'b1, 1'b0, 1'b0, 7'd8);
        send(64'h96, 64'h0F, 8, 1'b0);
        check("R2 mode1 mosi", got_mosi, 64'h96);
        check("R2 mode1 miso", got_miso, 64'h0F);

        configure(1'b1, 1'b0, 1'b0, 1'b0, 7'd8);
        send(64'h5E, 64'hC3, 8, 1'b0);
        check("R2 mode2 mosi", got_mosi, 64'h5E);

        configure(1'b1, 1'b1, 1'b0, 1'b0, 7'd8);
        send(64'h81, 64'h7E, 8, 1'b0);
        check("R2 mode3 mosi", got_mosi, 64'h81);
        check("R2 mode3 miso", got_miso, 64'h7E);

        // R5 LSB first
        configure(1'b0, 1'b0, 1'b1, 1'b0, 7'd8);
        send(64'h1D, 64'hB2, 8, 1'b0);
        check("R5 lsb mosi", got_mosi, 64'h1D);
        check("R5 lsb miso", got_miso, 64'hB2);

        // R7 word lengths
        configure(1'b0, 1'b0, 1'b0, 1'b0, 7'd1);
        send(64'h1, 64'h0, 1, 1'b0);
        send(64'h0, 64'h1, 1, 1'b0);
        check("R7 len1 mosi", got_mosi, 64'h0);
        check("R7 len1 miso", got_miso, 64'h1);
        configure(1'b0, 1'b0, 1'b0, 1'b0, 7'd13);
        send(64'h1ABC, 64'h0123, 13, 1'b0);
        check("R7 len13 mosi", got_mosi, 64'h1ABC);
        check("R7 len13 miso", got_miso, 64'h0123);
        configure(1'b0, 1'b1, 1'b1, 1'b0, 7'd64);
        send(64'hDEADBEEF_01234567, 64'h8000_0000_0000_0001, 64, 1'b0);
        check("R7 len64 mosi", got_mosi, 64'hDEADBEEF_01234567);
        check("R7 len64 miso", got_miso, 64'h8000_0000_0000_0001);

        // R3 held clock, toggling data
        configure(1'b0, 1'b0, 1'b0, 1'b0, 7'd8);
        n0 = got_n;
        for (int t = 0; t < 40; t++) begin
            spi_mosi = ~spi_mosi; spi_miso = t[1]; spi_cs = t[2];
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        check("R3 no word while sck held", 64'(got_n - n0), 64'd0);
        check("R3 count unchanged", 64'(word_count), 64'd0);

        // R9 inactive select flagged, then cleared
        send(64'h42, 64'h24, 8, 1'b1);
        check("R9 inactive cs warn", 64'(got_warn), 64'd1);
        check("R9 word still delivered", got_mosi, 64'h42);
        send(64'h43, 64'h34, 8, 1'b0);
        check("R9 warn cleared next word", 64'(got_warn), 64'd0);
        check("R8 count per word", 64'(word_count), 64'd2);

        // R10 active-high select
        configure(1'b0, 1'b0, 1'b0, 1'b1, 7'd8);
        send(64'h11, 64'h22, 8, 1'b1);
        check("R10 active-high asserted", 64'(got_warn), 64'd0);
        send(64'h33, 64'h44, 8, 1'b0);
        check("R10 active-high idle warns", 64'(got_warn), 64'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule